// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block guards read-after-write dependences in a five-stage in-order integer pipeline made up of fetch, decode with register read, execute, memory and writeback. Each cycle it takes the two source register numbers of the instruction in decode. It matches them against the destination registers of the older instructions that are then in execute, memory and writeback and that are writing a register. Only read-after-write needs action. Read-after-read, write-after-read and write-after-write pairs pass without effect.

A mode input selects between two ways of resolving a hazard. In stall-only mode the unit holds the program counter and the fetch/decode buffer and puts a bubble into the decode-to-execute buffer. The register file cannot write and then read the same register in one cycle, so a consumer waits until its producer has fully left writeback. In forwarding mode the unit never stalls. It records in decode which older stage produces each operand. In the next cycle it steers that value into the execute operand. The value comes from the memory-stage result, from the writeback-stage result, or from a one-entry copy of the value that was leaving writeback when the consumer was in decode.

Top module: `hazard_interlock`

## Requirements
- R1: While `rst` is high, the operand selects are cleared. In the cycle after any clock edge taken in reset, `fwd_sel_a`/`fwd_sel_b` read 0 and each `ex_opnd` equals its `ex_rf` input.
- R2: In stall-only mode (`fwd_mode`=0), a valid decode source that is not register 0 and that equals the destination of a writing instruction in execute, memory or writeback raises `pc_hold`, `ifid_hold` and `idex_bubble` together in that same cycle.
- R3: In stall-only mode the three hold outputs stay low when no source matches. This also covers a match whose write enable is low and the case where `id_valid` is low.
- R4: In forwarding mode (`fwd_mode`=1) the hold outputs are never raised.
- R5: In forwarding mode, a source matched in execute during decode gives select code 1 in the next cycle, and the operand equals `mem_result`.
- R6: A source matched in memory (and not in execute) gives select code 2 in the next cycle, and the operand equals `wb_result`.
- R7: A source matched only in writeback gives select code 3 in the next cycle, and the operand equals the `wb_result` present during the decode cycle.
- R8: When several stages match, the youngest one wins: execute comes before memory, and memory comes before writeback.
- R9: Register 0 never causes a hold and is never forwarded. The select stays 0 and the operand is the register-file value.
- R10: In stall-only mode, and for any bubble, the select registered for the next cycle is 0 (register file), so the operand equals `ex_rf_a`/`ex_rf_b`.
- R11: On a program of two independent back-to-back dependent pairs, stall-only mode inserts 3 bubbles per pair (6 in all) and forwarding mode inserts none. Both modes give the same architectural results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_mode | input | 1 | 0 = stall-only, 1 = forwarding |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | AW | First source register of decode instruction |
| id_rs2 | input | AW | Second source register of decode instruction |
| ex_rd | input | AW | Destination register of execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_rf_a | input | DW | First operand as read from the register file |
| ex_rf_b | input | DW | Second operand as read from the register file |
| mem_rd | input | AW | Destination register of memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_result | input | DW | Result carried by the memory-stage instruction |
| wb_rd | input | AW | Destination register of writeback instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| wb_result | input | DW | Result carried by the writeback instruction |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode buffer |
| idex_bubble | output | 1 | Load a no-op with write enable cleared into the decode/execute buffer |
| fwd_sel_a | output | 2 | Source of operand A: 0 rf, 1 mem, 2 wb, 3 retained |
| fwd_sel_b | output | 2 | Source of operand B, same coding |
| ex_opnd_a | output | DW | Operand A for execute |
| ex_opnd_b | output | DW | Operand B for execute |

## Verification
A sweep on a four-register slice goes through every decode source against every destination in execute, memory and writeback, with every write-enable pattern, in both modes and for both operands. Single-stage matches separate the three forwarding paths. Multi-stage matches expose a wrong priority. Disabled writes, invalid decode and register 0 separate true hazards from false ones. A small closed-loop pipeline model then runs two short programs in both modes. Back-to-back pairs pin the bubble count to exactly three per pair. A mixed-distance program reaches the retained-value path and checks that both modes give the same final register values.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Where an execute operand comes from; encoded values are visible on ports.
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,   // value read from the register file in decode
        SRC_MEM = 2'd1,   // producer was in execute during decode
        SRC_WB  = 2'd2,   // producer was in memory during decode
        SRC_RET = 2'd3    // producer was in writeback during decode
    } opnd_src_e;

    // One source compared against the three older stages.
    typedef struct packed {
        logic in_ex;
        logic in_mem;
        logic in_wb;
    } hit_vec_t;

    // Youngest producer wins.
    function automatic opnd_src_e pick_src(input hit_vec_t h);
        if (h.in_ex)  return SRC_MEM;
        if (h.in_mem) return SRC_WB;
        if (h.in_wb)  return SRC_RET;
        return SRC_RF;
    endfunction

    function automatic logic any_hit(input hit_vec_t h);
        return h.in_ex | h.in_mem | h.in_wb;
    endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          src_valid,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output hit_vec_t      hits
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    logic live;

    // Register 0 is constant; reading it never depends on anything.
    assign live = src_valid && (src != ZERO_REG);

    always_comb begin
        hits.in_ex  = live && ex_we  && (ex_rd  == src);
        hits.in_mem = live && mem_we && (mem_rd == src);
        hits.in_wb  = live && wb_we  && (wb_rd  == src);
    end

endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl
    import hz_pkg::*;
#(
    parameter int NS = 2
) (
    input  logic                fwd_mode,
    input  hit_vec_t [NS-1:0]   hits,
    output logic                stall
);

    // Without forwarding, any pending producer of any source blocks decode
    // until it has retired from writeback.
    always_comb begin
        stall = 1'b0;
        if (!fwd_mode) begin
            for (int i = 0; i < NS; i++) begin
                stall = stall | any_hit(hits[i]);
            end
        end
    end

endmodule

// File: rtl/hz_ret_latch.sv
module hz_ret_latch #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] wb_result,
    output logic [DW-1:0] ret_data
);

    // Copy of the value leaving writeback; covers the cycle in which the
    // register file write is not yet readable.
    always_ff @(posedge clk) begin
        if (rst) ret_data <= '0;
        else     ret_data <= wb_result;
    end

endmodule

// File: rtl/hz_fwd_path.sv
module hz_fwd_path
    import hz_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwd_mode,
    input  logic          stall,
    input  hit_vec_t      hits,
    input  logic [DW-1:0] mem_result,
    input  logic [DW-1:0] wb_result,
    input  logic [DW-1:0] ret_data,
    input  logic [DW-1:0] rf_data,
    output opnd_src_e     sel,
    output logic [DW-1:0] opnd
);

    opnd_src_e sel_d;
    opnd_src_e sel_q;

    // Decided in decode, travels with the instruction into execute.
    always_comb begin
        if (!fwd_mode || stall) sel_d = SRC_RF;
        else                    sel_d = pick_src(hits);
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= SRC_RF;
        else     sel_q <= sel_d;
    end

    always_comb begin
        unique case (sel_q)
            SRC_MEM: opnd = mem_result;
            SRC_WB:  opnd = wb_result;
            SRC_RET: opnd = ret_data;
            default: opnd = rf_data;
        endcase
    end

    assign sel = sel_q;

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
    import hz_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwd_mode,
    input  logic          id_valid,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic [DW-1:0] ex_rf_a,
    input  logic [DW-1:0] ex_rf_b,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [DW-1:0] mem_result,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    input  logic [DW-1:0] wb_result,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic [DW-1:0] ex_opnd_a,
    output logic [DW-1:0] ex_opnd_b
);

    localparam int NS = 2;

    logic [NS-1:0][AW-1:0] src_vec;
    logic [NS-1:0][DW-1:0] rf_vec;
    logic [NS-1:0][DW-1:0] opnd_vec;
    hit_vec_t [NS-1:0]     hits;
    opnd_src_e             sel_vec [NS];
    logic [DW-1:0]         ret_data;
    logic                  stall;

    assign src_vec = {id_rs2, id_rs1};
    assign rf_vec  = {ex_rf_b, ex_rf_a};

    hz_ret_latch #(.DW(DW)) ret_i (
        .clk       (clk),
        .rst       (rst),
        .wb_result (wb_result),
        .ret_data  (ret_data)
    );

    for (genvar g = 0; g < NS; g++) begin : g_src
        hz_match #(.AW(AW)) match_i (
            .src_valid (id_valid),
            .src       (src_vec[g]),
            .ex_rd     (ex_rd),
            .ex_we     (ex_we),
            .mem_rd    (mem_rd),
            .mem_we    (mem_we),
            .wb_rd     (wb_rd),
            .wb_we     (wb_we),
            .hits      (hits[g])
        );

        hz_fwd_path #(.DW(DW)) path_i (
            .clk        (clk),
            .rst        (rst),
            .fwd_mode   (fwd_mode),
            .stall      (stall),
            .hits       (hits[g]),
            .mem_result (mem_result),
            .wb_result  (wb_result),
            .ret_data   (ret_data),
            .rf_data    (rf_vec[g]),
            .sel        (sel_vec[g]),
            .opnd       (opnd_vec[g])
        );
    end

    hz_stall_ctl #(.NS(NS)) stall_i (
        .fwd_mode (fwd_mode),
        .hits     (hits),
        .stall    (stall)
    );

    assign pc_hold     = stall;
    assign ifid_hold   = stall;
    assign idex_bubble = stall;
    assign fwd_sel_a   = sel_vec[0];
    assign fwd_sel_b   = sel_vec[1];
    assign ex_opnd_a   = opnd_vec[0];
    assign ex_opnd_b   = opnd_vec[1];

endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          fwd_mode,
    input logic          id_valid,
    input logic [AW-1:0] id_rs1,
    input logic [AW-1:0] id_rs2,
    input logic [AW-1:0] ex_rd,
    input logic          ex_we,
    input logic [DW-1:0] ex_rf_a,
    input logic [AW-1:0] mem_rd,
    input logic          mem_we,
    input logic [DW-1:0] mem_result,
    input logic [AW-1:0] wb_rd,
    input logic          wb_we,
    input logic [DW-1:0] wb_result,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          idex_bubble,
    input logic [1:0]    fwd_sel_a,
    input logic [DW-1:0] ex_opnd_a
);

    logic a_ex, a_mem, a_wb;
    assign a_ex  = id_valid && (id_rs1 != '0) && ex_we  && (ex_rd  == id_rs1);
    assign a_mem = id_valid && (id_rs1 != '0) && mem_we && (mem_rd == id_rs1);
    assign a_wb  = id_valid && (id_rs1 != '0) && wb_we  && (wb_rd  == id_rs1);

    assert_hold_agree_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));

    assert_stall_on_match_R2: assert property (@(posedge clk) disable iff (rst)
        (!fwd_mode && (a_ex || a_mem || a_wb)) |-> pc_hold);

    assert_idle_no_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !pc_hold);

    assert_fwd_never_holds_R4: assert property (@(posedge clk) disable iff (rst)
        fwd_mode |-> !pc_hold);

    assert_mem_path_R5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && fwd_mode && a_ex) |-> (ex_opnd_a == mem_result));

    assert_ret_path_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && fwd_mode && a_wb && !a_ex && !a_mem) |-> (ex_opnd_a == $past(wb_result)));

    assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
        (id_rs1 == '0 && id_rs2 == '0) |-> !pc_hold);

    assert_stall_mode_rf_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!fwd_mode) |-> (fwd_sel_a == 2'd0 && ex_opnd_a == ex_rf_a));

endmodule

bind hazard_interlock hazard_interlock_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/hazard_interlock_tb_top.sv
`timescale 1ns/1ps
module hazard_interlock_tb_top;

    localparam int AW = 5;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fwd_mode = 1'b0;
    logic          id_valid = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic          ex_we = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [DW-1:0] ex_rf_a = '0, ex_rf_b = '0, mem_result = '0, wb_result = '0;
    logic          pc_hold, ifid_hold, idex_bubble;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic [DW-1:0] ex_opnd_a, ex_opnd_b;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    hazard_interlock #(.AW(AW), .DW(DW)) dut_i (.*);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- closed-loop pipeline model ----------------
    int            regs [32];
    logic          sv   [4];   // 0 decode, 1 execute, 2 memory, 3 writeback
    logic          swe  [4];
    logic [AW-1:0] srd  [4], srs1 [4], srs2 [4];
    logic [DW-1:0] sa   [4], sb   [4], sres [4];
    int            p_rd [8], p_rs1 [8], p_rs2 [8];
    int            p_len;

    function automatic int init_val(input int r);
        return (r == 0) ? 0 : r * 7 + 5;
    endfunction

    task automatic apply_model();
        id_valid   = sv[0];
        id_rs1     = srs1[0];
        id_rs2     = srs2[0];
        ex_rd      = srd[1];
        ex_we      = sv[1] && swe[1];
        ex_rf_a    = sa[1];
        ex_rf_b    = sb[1];
        mem_rd     = srd[2];
        mem_we     = sv[2] && swe[2];
        mem_result = sres[2];
        wb_rd      = srd[3];
        wb_we      = sv[3] && swe[3];
        wb_result  = sres[3];
    endtask

    task automatic run_prog(input logic m, output int bubbles);
        int pc;
        logic h;
        logic [DW-1:0] oa, ob, rda, rdb;
        bubbles = 0;
        pc = 0;
        for (int r = 0; r < 32; r++) regs[r] = init_val(r);
        for (int s = 0; s < 4; s++) begin
            sv[s] = 0; swe[s] = 0; srd[s] = '0; srs1[s] = '0; srs2[s] = '0;
            sa[s] = '0; sb[s] = '0; sres[s] = '0;
        end
        apply_model();
        fwd_mode = m;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        repeat (24) begin
            @(negedge clk);
            h  = pc_hold;
            oa = ex_opnd_a;
            ob = ex_opnd_b;
            if (h) bubbles++;
            @(posedge clk);
            #1;
            rda = DW'(regs[srs1[0]]);
            rdb = DW'(regs[srs2[0]]);
            if (sv[3] && swe[3] && srd[3] != 0) regs[srd[3]] = int'(sres[3]);
            sv[3] = sv[2]; swe[3] = swe[2]; srd[3] = srd[2]; sres[3] = sres[2];
            sv[2] = sv[1]; swe[2] = swe[1]; srd[2] = srd[1]; sres[2] = oa + ob;
            if (h) begin
                sv[1] = 0; swe[1] = 0; srd[1] = '0; sa[1] = '0; sb[1] = '0;
            end else begin
                sv[1] = sv[0]; swe[1] = swe[0]; srd[1] = srd[0]; sa[1] = rda; sb[1] = rdb;
                if (pc < p_len) begin
                    sv[0] = 1; swe[0] = 1;
                    srd[0]  = AW'(p_rd[pc]);
                    srs1[0] = AW'(p_rs1[pc]);
                    srs2[0] = AW'(p_rs2[pc]);
                end else begin
                    sv[0] = 0; swe[0] = 0; srd[0] = '0; srs1[0] = '0; srs2[0] = '0;
                end
                pc++;
            end
            apply_model();
        end
    endtask

    task automatic load_pairs();
        p_len = 4;
        p_rd[0] = 1;  p_rs1[0] = 2;  p_rs2[0] = 3;
        p_rd[1] = 4;  p_rs1[1] = 1;  p_rs2[1] = 1;
        p_rd[2] = 11; p_rs1[2] = 12; p_rs2[2] = 13;
        p_rd[3] = 14; p_rs1[3] = 11; p_rs2[3] = 11;
    endtask

    task automatic load_mixed();
        p_len = 4;
        p_rd[0] = 5; p_rs1[0] = 2;  p_rs2[0] = 3;
        p_rd[1] = 6; p_rs1[1] = 12; p_rs2[1] = 13;
        p_rd[2] = 7; p_rs1[2] = 11; p_rs2[2] = 11;
        p_rd[3] = 8; p_rs1[3] = 5;  p_rs2[3] = 6;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int bub;
        // R1: reset clears selects even with a forwarding match pending
        fwd_mode = 1'b1; id_valid = 1'b1; id_rs1 = 5'd3; ex_rd = 5'd3; ex_we = 1'b1;
        ex_rf_a = 32'hCAFE_0001; mem_result = 32'hBAD0_0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 sel", 32'(fwd_sel_a), 32'd0);
        check("R1 opnd", ex_opnd_a, 32'hCAFE_0001);
        @(posedge clk);
        #1 rst = 1'b0;
        id_valid = 1'b0; ex_we = 1'b0;

        // exhaustive sweep over a four-register slice
        for (int m = 0; m < 2; m++)
        for (int op = 0; op < 2; op++)
        for (int v = 0; v < 2; v++)
        for (int s = 0; s < 4; s++)
        for (int er = 0; er < 4; er++)
        for (int mr = 0; mr < 4; mr++)
        for (int wr = 0; wr < 4; wr++)
        for (int we = 0; we < 8; we++) begin
            logic he, hm, hw, hold_exp;
            logic [1:0] sel_exp;
            logic [DW-1:0] old_wb, mv, wv, fa, fb, o_exp;
            string tag;
            int idx;
            idx    = ((((((m*2+op)*2+v)*4+s)*4+er)*4+mr)*4+wr)*8+we;
            old_wb = 32'h5000_0000 | DW'(idx);
            fwd_mode = m[0];
            id_valid = v[0];
            id_rs1 = (op == 0) ? AW'(s) : '0;
            id_rs2 = (op == 1) ? AW'(s) : '0;
            ex_rd = AW'(er); mem_rd = AW'(mr); wb_rd = AW'(wr);
            ex_we = we[0]; mem_we = we[1]; wb_we = we[2];
            wb_result = old_wb;
            mem_result = 32'hDEAD_0000;
            he = v[0] && s != 0 && we[0] && er == s;
            hm = v[0] && s != 0 && we[1] && mr == s;
            hw = v[0] && s != 0 && we[2] && wr == s;
            hold_exp = (m == 0) && (he || hm || hw);
            if (m == 1)      tag = "R4";
            else if (s == 0) tag = "R9";
            else if (hold_exp) tag = "R2";
            else             tag = "R3";
            @(negedge clk);
            check({tag, " hold"}, {29'd0, pc_hold, ifid_hold, idex_bubble}, {29'd0, {3{hold_exp}}});
            @(posedge clk);
            #1;
            mv = 32'h1000_0000 | DW'(idx);
            wv = 32'h2000_0000 | DW'(idx);
            fa = 32'h3000_0000 | DW'(idx);
            fb = 32'h4000_0000 | DW'(idx);
            id_valid = 1'b0; ex_we = 1'b0; mem_we = 1'b0; wb_we = 1'b0;
            mem_result = mv; wb_result = wv; ex_rf_a = fa; ex_rf_b = fb;
            if (m == 0)  begin sel_exp = 2'd0; o_exp = (op == 0) ? fa : fb; end
            else if (he) begin sel_exp = 2'd1; o_exp = mv; end
            else if (hm) begin sel_exp = 2'd2; o_exp = wv; end
            else if (hw) begin sel_exp = 2'd3; o_exp = old_wb; end
            else         begin sel_exp = 2'd0; o_exp = (op == 0) ? fa : fb; end
            if (m == 0)                         tag = "R10";
            else if (s == 0)                    tag = "R9";
            else if (he && (hm || hw))          tag = "R8";
            else if (he)                        tag = "R5";
            else if (hm && hw)                  tag = "R8";
            else if (hm)                        tag = "R6";
            else if (hw)                        tag = "R7";
            else                                tag = "R3";
            @(negedge clk);
            if (op == 0) begin
                check({tag, " sel"}, 32'(fwd_sel_a), 32'(sel_exp));
                check({tag, " opnd"}, ex_opnd_a, o_exp);
            end else begin
                check({tag, " sel"}, 32'(fwd_sel_b), 32'(sel_exp));
                check({tag, " opnd"}, ex_opnd_b, o_exp);
            end
            @(posedge clk);
            #1;
        end

        // R11: two back-to-back dependent pairs
        for (int m = 0; m < 2; m++) begin
            load_pairs();
            run_prog(m[0], bub);
            check("R11 bubbles", 32'(bub), (m == 0) ? 32'd6 : 32'd0);
            check("R11 r4", 32'(regs[4]), 32'(2 * (init_val(2) + init_val(3))));
            check("R11 r14", 32'(regs[14]), 32'(2 * (init_val(12) + init_val(13))));
        end

        // R7: mixed distances reach the retained-value path
        for (int m = 0; m < 2; m++) begin
            load_mixed();
            run_prog(m[0], bub);
            check("R7 bubbles", 32'(bub), (m == 0) ? 32'd2 : 32'd0);
            check("R7 r8", 32'(regs[8]),
                  32'(init_val(2) + init_val(3) + init_val(12) + init_val(13)));
            check("R7 r7", 32'(regs[7]), 32'(2 * init_val(11)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule